// File: doc/BRIEF.md
# Constant-Latency Interrupt Entry Unit

This unit owns the program counter and the status word of a processor whose instructions all take one clock, and it makes the interrupt response time fixed. A synchronous request is taken in the same cycle that it is seen, provided the global interrupt-enable bit of the status word is set. In that cycle the unit does three things. It asserts a kill strobe, so the instruction at the current program counter does not issue. It pushes that instruction's address onto a return stack and the current status word onto a data stack, both in the same cycle. It loads a fixed vector into the program counter. The first vector fetch therefore always comes exactly one clock after the request, whatever instruction was running.

A return operation pops both stacks together and restores the program counter and the status word in one cycle. Because the saved status word still holds the enable bit, the return re-enables interrupts. The suppressed instruction runs again after the return. A request that arrives while interrupts are disabled is held pending until the enable bit comes back. The two stacks always move together. An entry that would overflow either stack, or a return that would underflow either one, leaves both stacks untouched and sets sticky flags.

Top module: `irq_entry_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals RESET_PC, `psw_o` is all zeros (interrupts disabled), `kill_o` is 0, and all five flag outputs are 0.
- R2: In a cycle with no entry and no return, `pc_o` takes `next_pc_i` at the next edge. `psw_o` takes `psw_i` if `psw_we_i` is high and otherwise keeps its value.
- R3: A cycle takes an interrupt when (`irq_i` is high or a request is pending) and bit IE_BIT of `psw_o` is 1. In that cycle `kill_o` is 1, and after the next edge `pc_o` equals VECTOR. No other cycle raises `kill_o`.
- R4: On entry, the value of `pc_o` and the value of `psw_o` in the entry cycle are pushed together. The new `psw_o` equals the old one with only bit IE_BIT cleared, and `psw_we_i` is ignored.
- R5: `ret_i` in a cycle with no entry and both stacks non-empty pops both stacks. After the next edge, `pc_o` and `psw_o` hold the most recently saved pair.
- R6: A request seen while bit IE_BIT is 0 is remembered, even a single-cycle pulse. It is taken in the first cycle in which bit IE_BIT reads 1, and it is cleared once taken.
- R7: When an entry and `ret_i` fall in the same cycle, the entry wins and the stacks are not popped.
- R8: An entry made while either stack holds DEPTH entries pushes nothing. It still loads VECTOR and clears bit IE_BIT, and it sets `err_o`, `rs_ovf_o` and `ds_ovf_o`. All three stay set until reset.
- R9: A return made while either stack is empty pops nothing. It sets `rs_unf_o` and `ds_unf_o`, which stay set until reset. `pc_o` takes `next_pc_i` and `psw_o` is unchanged.
- R10: Nested entries return in reverse order: each return restores the pair saved by the most recent entry that has not yet been returned from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | Synchronous interrupt request |
| ret_i | input | 1 | Return-from-interrupt issued this cycle |
| next_pc_i | input | PC_W | Next address chosen by the core for normal flow |
| psw_we_i | input | 1 | Status word write strobe |
| psw_i | input | PSW_W | Status word write data |
| pc_o | output | PC_W | Address of the instruction issuing this cycle |
| psw_o | output | PSW_W | Current status word |
| kill_o | output | 1 | Suppress the instruction at pc_o (entry cycle) |
| rs_ovf_o | output | 1 | Sticky return-stack overflow |
| rs_unf_o | output | 1 | Sticky return-stack underflow |
| ds_ovf_o | output | 1 | Sticky data-stack overflow |
| ds_unf_o | output | 1 | Sticky data-stack underflow |
| err_o | output | 1 | Sticky error: entry refused for lack of stack space |

## Verification
The bench builds the unit with DEPTH=4, PC_W=8, PSW_W=4, IE_BIT=0 and VECTOR=8'hF0. With a stack only four entries deep, a few nested entries reach overflow and a few returns reach underflow, so both boundaries are hit many times during a pseudo-random sweep of two thousand cycles. The narrow status word lets random writes toggle the enable bit often, which exercises pending requests, release on re-enable, and entry colliding with a return. A cycle-accurate model in the bench predicts the kill strobe, the program counter, the status word and every flag on each clock.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    OP_SEQ   = 2'd0,
    OP_ENTRY = 2'd1,
    OP_RET   = 2'd2
  } irq_op_e;
endpackage

// File: rtl/irq_lifo.sv
module irq_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_req_i,
  input  logic         push_ok_i,
  input  logic         pop_req_i,
  input  logic         pop_ok_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_idx;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_req_i & push_ok_i;
  assign do_pop  = pop_req_i & pop_ok_i;
  assign top_idx = cnt_q - CW'(1);
  assign top_o   = empty_o ? '0 : mem_q[top_idx[PTR_W-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[cnt_q[PTR_W-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (do_push)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop)  cnt_q <= cnt_q - CW'(1);
      if (push_req_i && full_o) ovf_o <= 1'b1;
      if (pop_req_i && empty_o) unf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_entry_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    irq_i,
  input  logic    ret_i,
  input  logic    ie_i,
  output irq_op_e op_o
);
  logic pend_q, take;

  // level or pulse both latch; cleared only by the entry that serves it
  assign take = (irq_i | pend_q) & ie_i;

  always_comb begin
    if (take)       op_o = OP_ENTRY;
    else if (ret_i) op_o = OP_RET;
    else            op_o = OP_SEQ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q | irq_i) & ~take;
  end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          PSW_W    = 8,
  parameter int          IE_BIT   = 0,
  parameter int          DEPTH    = 8,
  parameter logic [15:0] VECTOR   = 16'h0010,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             ret_i,
  input  logic [PC_W-1:0]  next_pc_i,
  input  logic             psw_we_i,
  input  logic [PSW_W-1:0] psw_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PSW_W-1:0] psw_o,
  output logic             kill_o,
  output logic             rs_ovf_o,
  output logic             rs_unf_o,
  output logic             ds_ovf_o,
  output logic             ds_unf_o,
  output logic             err_o
);
  localparam logic [PC_W-1:0]  VEC_PC  = PC_W'(VECTOR);
  localparam logic [PC_W-1:0]  RST_PC  = PC_W'(RESET_PC);
  localparam logic [PSW_W-1:0] IE_MASK = PSW_W'(1) << IE_BIT;

  irq_op_e          op;
  logic [PC_W-1:0]  pc_q, pc_d, rs_top;
  logic [PSW_W-1:0] psw_q, psw_d, ds_top;
  logic             err_q;
  logic             rs_full, rs_empty, ds_full, ds_empty;
  logic             push_req, pop_req, push_ok, pop_ok;

  irq_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .ret_i  (ret_i),
    .ie_i   (psw_q[IE_BIT]),
    .op_o   (op)
  );

  assign push_req = (op == OP_ENTRY);
  assign pop_req  = (op == OP_RET);
  // both stacks move together or not at all
  assign push_ok  = ~rs_full & ~ds_full;
  assign pop_ok   = ~rs_empty & ~ds_empty;

  irq_lifo #(.W(PC_W), .DEPTH(DEPTH)) u_rstk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_req_i (push_req),
    .push_ok_i  (push_ok),
    .pop_req_i  (pop_req),
    .pop_ok_i   (pop_ok),
    .din_i      (pc_q),
    .top_o      (rs_top),
    .full_o     (rs_full),
    .empty_o    (rs_empty),
    .ovf_o      (rs_ovf_o),
    .unf_o      (rs_unf_o)
  );

  irq_lifo #(.W(PSW_W), .DEPTH(DEPTH)) u_dstk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_req_i (push_req),
    .push_ok_i  (push_ok),
    .pop_req_i  (pop_req),
    .pop_ok_i   (pop_ok),
    .din_i      (psw_q),
    .top_o      (ds_top),
    .full_o     (ds_full),
    .empty_o    (ds_empty),
    .ovf_o      (ds_ovf_o),
    .unf_o      (ds_unf_o)
  );

  always_comb begin
    pc_d  = next_pc_i;
    psw_d = psw_q;
    unique case (op)
      OP_ENTRY: begin
        pc_d  = VEC_PC;
        psw_d = psw_q & ~IE_MASK;
      end
      OP_RET: begin
        if (pop_ok) begin
          pc_d  = rs_top;
          psw_d = ds_top;
        end
      end
      default: begin
        if (psw_we_i) psw_d = psw_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RST_PC;
      psw_q <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      psw_q <= psw_d;
      if (push_req && !push_ok) err_q <= 1'b1;
    end
  end

  assign pc_o   = pc_q;
  assign psw_o  = psw_q;
  assign kill_o = push_req;
  assign err_o  = err_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int          PC_W   = 16,
  parameter int          PSW_W  = 8,
  parameter int          IE_BIT = 0,
  parameter logic [15:0] VECTOR = 16'h0010
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_i,
  input logic             ret_i,
  input logic [PC_W-1:0]  next_pc_i,
  input logic             psw_we_i,
  input logic [PSW_W-1:0] psw_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [PSW_W-1:0] psw_o,
  input logic             kill_o,
  input logic             rs_ovf_o,
  input logic             rs_unf_o,
  input logic             ds_ovf_o,
  input logic             ds_unf_o,
  input logic             err_o
);
  a_r3_vector_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |=> (pc_o == PC_W'(VECTOR)));
  a_r3_kill_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> psw_o[IE_BIT]);
  a_r4_ie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |=> !psw_o[IE_BIT]);
  a_r6_enabled_irq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && psw_o[IE_BIT]) |-> kill_o);
  a_r2_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kill_o && !ret_i) |=> (pc_o == $past(next_pc_i)));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r8_err_with_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rs_ovf_o && ds_ovf_o));
  a_r9_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_unf_o && ds_unf_o) |=> (rs_unf_o && ds_unf_o));
endmodule

bind irq_entry_unit irq_entry_chk #(
  .PC_W(PC_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT), .VECTOR(VECTOR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ret_i(ret_i),
  .next_pc_i(next_pc_i), .psw_we_i(psw_we_i), .psw_i(psw_i),
  .pc_o(pc_o), .psw_o(psw_o), .kill_o(kill_o),
  .rs_ovf_o(rs_ovf_o), .rs_unf_o(rs_unf_o),
  .ds_ovf_o(ds_ovf_o), .ds_unf_o(ds_unf_o), .err_o(err_o)
);

// File: tb/test_irq_entry_unit.sv
module test_irq_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;
  localparam int PSW_W = 4;
  localparam int DEPTH = 4;
  localparam logic [7:0] VEC = 8'hF0;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic irq_i = 1'b0, ret_i = 1'b0, psw_we_i = 1'b0;
  logic [PC_W-1:0] next_pc_i = '0;
  logic [PSW_W-1:0] psw_i = '0;
  logic [PC_W-1:0] pc_o;
  logic [PSW_W-1:0] psw_o;
  logic kill_o, rs_ovf_o, rs_unf_o, ds_ovf_o, ds_unf_o, err_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_entry_unit #(
    .PC_W(PC_W), .PSW_W(PSW_W), .IE_BIT(0), .DEPTH(DEPTH),
    .VECTOR(16'h00F0), .RESET_PC(16'h0000)
  ) i_irq_entry_unit (
    .clk_i, .rst_ni, .irq_i, .ret_i, .next_pc_i, .psw_we_i, .psw_i,
    .pc_o, .psw_o, .kill_o, .rs_ovf_o, .rs_unf_o, .ds_ovf_o, .ds_unf_o, .err_o
  );

  int n_chk = 0, n_fail = 0;
  logic [PC_W-1:0] m_pc = '0;
  logic [PSW_W-1:0] m_psw = '0;
  logic m_pend = 0, m_err = 0, m_ovf = 0, m_unf = 0;
  logic [PC_W-1:0] m_rs [DEPTH];
  logic [PSW_W-1:0] m_ds [DEPTH];
  int m_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic irq, input logic ret, input logic [7:0] npc,
                      input logic we, input logic [3:0] pin, input string tag);
    logic take;
    string ptag, stag;
    irq_i = irq; ret_i = ret; next_pc_i = npc; psw_we_i = we; psw_i = pin;
    #1;
    take = (irq | m_pend) & m_psw[0];
    chk({tag, "/R3 kill"}, 16'(kill_o), 16'(take));
    if (take) begin
      ptag = "R3"; stag = "R4";
      if (m_cnt < DEPTH) begin
        m_rs[m_cnt] = m_pc; m_ds[m_cnt] = m_psw; m_cnt++;
      end else begin
        m_err = 1; m_ovf = 1; ptag = "R8"; stag = "R8";
      end
      m_pc = VEC; m_psw = m_psw & 4'b1110;
    end else if (ret) begin
      ptag = "R5"; stag = "R5";
      if (m_cnt > 0) begin
        m_cnt--; m_pc = m_rs[m_cnt]; m_psw = m_ds[m_cnt];
      end else begin
        m_unf = 1; m_pc = npc; ptag = "R9"; stag = "R9";
      end
    end else begin
      ptag = "R2"; stag = "R2";
      m_pc = npc;
      if (we) m_psw = pin;
    end
    m_pend = (m_pend | irq) & ~take;
    @(negedge clk_i);
    chk({tag, "/", ptag, " pc"}, 16'(pc_o), 16'(m_pc));
    chk({tag, "/", stag, " psw"}, 16'(psw_o), 16'(m_psw));
    chk({tag, "/flags"}, 16'({err_o, rs_ovf_o, ds_ovf_o, rs_unf_o, ds_unf_o}),
        16'({m_err, m_ovf, m_ovf, m_unf, m_unf}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    chk("R1 pc", 16'(pc_o), 16'h0);
    chk("R1 psw", 16'(psw_o), 16'h0);
    chk("R1 kill", 16'(kill_o), 16'h0);
    chk("R1 flags", 16'({err_o, rs_ovf_o, rs_unf_o, ds_ovf_o, ds_unf_o}), 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 normal flow
    step(0, 0, 8'h01, 0, 4'h0, "R2");
    step(0, 0, 8'h02, 1, 4'hA, "R2");
    // R6 pulse while disabled, held, taken once enabled
    step(1, 0, 8'h03, 0, 4'h0, "R6");
    step(0, 0, 8'h04, 0, 4'h0, "R6");
    step(0, 0, 8'h05, 1, 4'h7, "R6");
    step(0, 0, 8'h06, 0, 4'h0, "R6 taken");
    step(0, 0, 8'hF1, 0, 4'h0, "R6 cleared");
    // R5 return restores pc 8'h05 and psw 4'h7
    step(0, 1, 8'hF2, 0, 4'h0, "R5");
    step(0, 0, 8'h06, 0, 4'h0, "R5 after");
    // R7 entry wins over return
    step(1, 1, 8'h07, 0, 4'h0, "R7");
    step(0, 1, 8'hF1, 0, 4'h0, "R7 ret");
    // R10 nesting three deep
    step(0, 0, 8'h20, 1, 4'h3, "R10");
    step(1, 0, 8'h21, 0, 4'h0, "R10");
    step(0, 0, 8'hF1, 1, 4'h5, "R10");
    step(1, 0, 8'hF2, 0, 4'h0, "R10");
    step(0, 0, 8'hF1, 1, 4'h9, "R10");
    step(1, 0, 8'hF2, 0, 4'h0, "R10");
    step(0, 1, 8'h00, 0, 4'h0, "R10");
    step(0, 1, 8'h00, 0, 4'h0, "R10");
    step(0, 1, 8'h00, 0, 4'h0, "R10");
    // R9 underflow
    step(0, 1, 8'h44, 0, 4'h0, "R9");
    step(0, 1, 8'h45, 0, 4'h0, "R9");
    step(0, 0, 8'h46, 1, 4'h1, "R9");
    // R8 overflow: repeated entries with re-enable
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 8'h50, 0, 4'h0, "R8");
      step(0, 0, 8'hF1, 1, 4'h1, "R8");
    end
    // sweep
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'h0, lfsr[7:5] == 3'h0, lfsr[15:8],
           lfsr[10:9] == 2'b00, lfsr[14:11], "sweep");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule